// File: doc/BRIEF.md
# Thermometer Bubble Corrector and Encoder

This block sits behind a parallel comparator bank. Each sample is a thermometer word of 2^RES−1 bits, where RES is the output resolution and is set at elaboration (4 to 8). Bit 0 belongs to the lowest threshold. A clean word is a solid run of ones that starts at bit 0, with only zeros above it. Metastable or skewed comparators break that pattern. The block repairs the breaks with one of four strategies, chosen at run time. It then turns the repaired word into a RES-bit code, either in plain binary or in Gray, and registers the code on the sampling clock.

Each strategy has its own latency:
- Single-gap fill: 2 cycles.
- Majority vote: 2 cycles.
- Double-gap fill: 3 cycles.
- Temporal filter: 4 cycles.

A flag travels with every result. It tells downstream logic that the raw word needed repair. Changing the strategy drains the pipeline first, so each result is produced by exactly one strategy.

Top module: `therm_fix_encoder`

## Requirements
- R1: The thermometer input is 2^RES−1 bits wide. In binary format (`gray_i`=0), `code_o` is the number of ones in the repaired word. For a clean input word, that equals the position of its one-to-zero edge.
- R2: Mode 0 (single-gap fill) sets every zero bit whose two neighbours are both one. The neighbour below bit 0 counts as one and the neighbour above the top bit counts as zero. The result appears 2 cycles after the sample is taken.
- R3: A clean input word passes unchanged through modes 0, 1 and 2, so its code is its count of ones.
- R4: Mode 1 (double-gap fill) sets a zero bit when at least one of the two bits below it is one and at least one of the two bits above it is one. The same virtual ends as in R2 apply. This fills gaps of one or two zeros. The result appears 3 cycles after the sample is taken.
- R5: Mode 2 (majority) replaces each bit with the majority of itself and its two neighbours, using the R2 virtual ends. The result appears 2 cycles after the sample is taken.
- R6: Mode 3 (temporal filter) applies the mode-0 repair, then takes the per-bit majority of this sample's repaired word and those of the two previous accepted samples. The history reads as zero after reset and after any mode switch. The result appears 4 cycles after the sample is taken.
- R7: In Gray format (`gray_i`=1), `code_o` is b XOR (b>>1), where b is the R1 count. The format is applied at the output register, so codes of adjacent counts differ in exactly one bit.
- R8: `bubble_o` is high together with `valid_o` exactly when the raw word was not clean.
- R9: `valid_o` pulses once for each accepted sample, at that mode's latency, and is low otherwise. `code_o` holds its value between results.
- R10: While `mode_i` differs from the active mode, input samples are discarded and `valid_o` stays low. The new mode becomes active after 5 consecutive such cycles.
- R11: After reset, `valid_o`, `bubble_o` and `code_o` are zero and the active mode is mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_i | input | 2^RES−1 | Raw comparator word, bit 0 is the lowest threshold |
| valid_i | input | 1 | Sample strobe |
| mode_i | input | 2 | Repair strategy: 0 single gap, 1 double gap, 2 majority, 3 temporal |
| gray_i | input | 1 | Output format: 0 binary, 1 Gray |
| code_o | output | RES | Encoded result |
| valid_o | output | 1 | Result strobe |
| bubble_o | output | 1 | Raw word of this result was not clean |

## Verification
The assertions check the following on every cycle:
- A clean word leaves the single-stage repair unaltered.
- The double-gap and temporal paths hold a sample for exactly their stage counts.
- Consecutive Gray results one count apart differ in a single bit.
- No result emerges in the cycle after a mode mismatch is seen.

Only the bench's scenarios can show the rest. That covers the repaired values for each strategy, including the virtual end bits. It also covers the zeroed history at the start of a temporal run, the bubble flag, the exact five-cycle switching delay, and the per-mode arrival cycle of each result.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

  typedef enum logic [1:0] {
    MODE_ONE = 2'd0,
    MODE_TWO = 2'd1,
    MODE_MAJ = 2'd2,
    MODE_TMF = 2'd3
  } fix_mode_e;

  // cycles a mode mismatch must persist before the new mode is adopted;
  // exceeds the deepest path so the pipeline is empty at the switch
  localparam int unsigned DRAIN_CYCLES = 5;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/tfe_bubble_fix.sv
module tfe_bubble_fix
  import tfe_pkg::*;
#(
  parameter int unsigned RES = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fix_mode_e             mode,
  input  logic                  in_v,
  input  logic [(1<<RES)-2:0]   in_w,
  input  logic                  in_bub,
  output logic                  out_v,
  output logic [(1<<RES)-2:0]   out_w,
  output logic                  out_bub
);
  localparam int unsigned TW = (1 << RES) - 1;

  // two virtual ones below bit 0, two virtual zeros above the top bit
  logic [TW+3:0] ext;
  logic [TW-1:0] one_w, maj_w, lo_c, hi_c, two_w;

  assign ext = {2'b00, in_w, 2'b11};

  for (genvar i = 0; i < TW; i++) begin : g_bit
    assign one_w[i] = ext[i+2] | (ext[i+1] & ext[i+3]);
    assign maj_w[i] = maj3(ext[i+1], ext[i+2], ext[i+3]);
    assign lo_c[i]  = ext[i+1] | ext[i];
    assign hi_c[i]  = ext[i+3] | ext[i+4];
  end

  // single stage path (modes one, majority, temporal)
  logic          a_v, a_bub;
  logic [TW-1:0] a_w;
  // two stage path (double gap)
  logic          s_v, s_bub, b_v, b_bub;
  logic [TW-1:0] s_w, s_lo, s_hi, b_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v <= 1'b0;
      s_v <= 1'b0;
      b_v <= 1'b0;
    end else begin
      a_v <= in_v && (mode != MODE_TWO);
      s_v <= in_v && (mode == MODE_TWO);
      b_v <= s_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      a_w   <= (mode == MODE_MAJ) ? maj_w : one_w;
      a_bub <= in_bub;
      s_w   <= in_w;
      s_lo  <= lo_c;
      s_hi  <= hi_c;
      s_bub <= in_bub;
    end
    b_w   <= two_w;
    b_bub <= s_bub;
  end

  assign two_w = s_w | (s_lo & s_hi);

  assign out_v   = (mode == MODE_TWO) ? b_v   : a_v;
  assign out_w   = (mode == MODE_TWO) ? b_w   : a_w;
  assign out_bub = (mode == MODE_TWO) ? b_bub : a_bub;

  // R3: a clean word survives the single stage repair untouched
  p_clean_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_v && (mode != MODE_TWO) && ((in_w & (in_w + TW'(1))) == '0))
      |=> (a_w == $past(in_w)))
    else $error("clean word altered by repair");

  // R4: the double gap path holds a sample for exactly two stages
  p_two_depth_r4: assert property (@(posedge clk) disable iff (rst)
    b_v |-> $past(in_v, 2))
    else $error("double gap path latency wrong");

endmodule

// File: rtl/tfe_time_filter.sv
module tfe_time_filter
  import tfe_pkg::*;
#(
  parameter int unsigned RES = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fix_mode_e             mode,
  input  logic                  flush,
  input  logic                  in_v,
  input  logic [(1<<RES)-2:0]   in_w,
  input  logic                  in_bub,
  output logic                  out_v,
  output logic [(1<<RES)-2:0]   out_w,
  output logic                  out_bub
);
  localparam int unsigned TW = (1 << RES) - 1;

  logic          active;
  logic [TW-1:0] h1, h2, vote;
  logic          v_v, v_bub, d_v, d_bub;
  logic [TW-1:0] v_w, d_w;

  assign active = (mode == MODE_TMF);
  assign vote   = (in_w & h1) | (in_w & h2) | (h1 & h2);

  // history of the two previous accepted repaired words
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      h1 <= '0;
      h2 <= '0;
    end else if (in_v && active) begin
      h1 <= in_w;
      h2 <= h1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_v <= 1'b0;
      d_v <= 1'b0;
    end else begin
      v_v <= in_v && active;
      d_v <= v_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v && active) begin
      v_w   <= vote;
      v_bub <= in_bub;
    end
    d_w   <= v_w;
    d_bub <= v_bub;
  end

  assign out_v   = active ? d_v   : in_v;
  assign out_w   = active ? d_w   : in_w;
  assign out_bub = active ? d_bub : in_bub;

  // R6: the filter adds exactly two stages
  p_filter_depth_r6: assert property (@(posedge clk) disable iff (rst)
    d_v |-> $past(in_v, 2))
    else $error("temporal filter latency wrong");

endmodule

// File: rtl/tfe_encoder.sv
module tfe_encoder #(
  parameter int unsigned RES = 6
) (
  input  logic [(1<<RES)-2:0] word,
  input  logic                gray,
  output logic [RES-1:0]      bin,
  output logic [RES-1:0]      code
);
  localparam int unsigned TW = (1 << RES) - 1;

  // count of ones; equals edge position for a monotonic word
  always_comb begin
    bin = '0;
    for (int i = 0; i < TW; i++) begin
      bin = bin + {{(RES-1){1'b0}}, word[i]};
    end
  end

  assign code = gray ? (bin ^ (bin >> 1)) : bin;

endmodule

// File: rtl/therm_fix_encoder.sv
module therm_fix_encoder
  import tfe_pkg::*;
#(
  parameter int unsigned RES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [(1<<RES)-2:0] therm_i,
  input  logic                valid_i,
  input  logic [1:0]          mode_i,
  input  logic                gray_i,
  output logic [RES-1:0]      code_o,
  output logic                valid_o,
  output logic                bubble_o
);
  localparam int unsigned TW = (1 << RES) - 1;
  localparam int unsigned CW = $clog2(DRAIN_CYCLES + 1);

  // ---------------- mode control ----------------
  fix_mode_e     act_mode;
  logic [CW-1:0] drain_cnt;
  logic          pend, switch_now;

  assign pend       = (mode_i != act_mode);
  assign switch_now = pend && (drain_cnt == CW'(DRAIN_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode  <= MODE_ONE;
      drain_cnt <= '0;
    end else if (switch_now) begin
      act_mode  <= fix_mode_e'(mode_i);
      drain_cnt <= '0;
    end else if (pend) begin
      drain_cnt <= drain_cnt + CW'(1);
    end else begin
      drain_cnt <= '0;
    end
  end

  // ---------------- capture stage ----------------
  logic          r_v, r_bub;
  logic [TW-1:0] r_w;

  always_ff @(posedge clk) begin
    if (rst) r_v <= 1'b0;
    else     r_v <= valid_i && !pend;
  end

  always_ff @(posedge clk) begin
    if (valid_i && !pend) begin
      r_w   <= therm_i;
      r_bub <= |(therm_i & (therm_i + TW'(1)));
    end
  end

  // ---------------- repair ----------------
  logic          f_v, f_bub, t_v, t_bub;
  logic [TW-1:0] f_w, t_w;

  tfe_bubble_fix #(.RES(RES)) u_fix (
    .clk    (clk),
    .rst    (rst),
    .mode   (act_mode),
    .in_v   (r_v),
    .in_w   (r_w),
    .in_bub (r_bub),
    .out_v  (f_v),
    .out_w  (f_w),
    .out_bub(f_bub)
  );

  tfe_time_filter #(.RES(RES)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .mode   (act_mode),
    .flush  (switch_now),
    .in_v   (f_v),
    .in_w   (f_w),
    .in_bub (f_bub),
    .out_v  (t_v),
    .out_w  (t_w),
    .out_bub(t_bub)
  );

  // ---------------- encode and retime ----------------
  logic [RES-1:0] enc_bin, enc_code, bin_q;

  tfe_encoder #(.RES(RES)) u_enc (
    .word(t_w),
    .gray(gray_i),
    .bin (enc_bin),
    .code(enc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      bubble_o <= 1'b0;
      code_o   <= '0;
      bin_q    <= '0;
    end else begin
      valid_o  <= t_v && !pend;
      bubble_o <= t_v && t_bub && !pend;
      if (t_v && !pend) begin
        code_o <= enc_code;
        bin_q  <= enc_bin;
      end
    end
  end

  // R7: back-to-back Gray results one count apart flip a single bit
  p_gray_step_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o) && $past(gray_i) && $past(gray_i, 2)
      && (bin_q == $past(bin_q) + RES'(1)))
      |-> ($countones(code_o ^ $past(code_o)) == 1))
    else $error("Gray step changed more than one bit");

  // R10: no result is released while a mode change is pending
  p_hold_low_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_i != act_mode) |=> !valid_o)
    else $error("result released during mode change");

endmodule

// File: tb/therm_fix_encoder_tb.sv
module therm_fix_encoder_tb;
  localparam int RES = 6;
  localparam int TW  = (1 << RES) - 1;
  typedef logic [TW-1:0] word_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  word_t          therm_i = '0;
  logic           valid_i = 1'b0;
  logic [1:0]     mode_i = 2'd0;
  logic           gray_i = 1'b0;
  logic [RES-1:0] code_o;
  logic           valid_o, bubble_o;

  therm_fix_encoder #(.RES(RES)) u_dut (
    .clk(clk), .rst(rst), .therm_i(therm_i), .valid_i(valid_i),
    .mode_i(mode_i), .gray_i(gray_i),
    .code_o(code_o), .valid_o(valid_o), .bubble_o(bubble_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0, errors = 0, cyc = 0;
  bit    done = 1'b0, mon_on = 1'b0;
  int    bmode = 0;
  bit    bgray = 1'b0;
  word_t h1 = '0, h2 = '0;

  int    exp_code [0:4095];
  bit    exp_bub  [0:4095];
  int    exp_due  [0:4095];
  string exp_tag  [0:4095];
  int    head = 0, tail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic bitv(word_t w, int i);
    if (i < 0) return 1'b1;
    if (i >= TW) return 1'b0;
    return w[i];
  endfunction

  function automatic word_t ref_one(word_t w);  // R2
    word_t o;
    for (int i = 0; i < TW; i++) o[i] = w[i] | (bitv(w, i-1) & bitv(w, i+1));
    return o;
  endfunction

  function automatic word_t ref_two(word_t w);  // R4
    word_t o;
    for (int i = 0; i < TW; i++)
      o[i] = w[i] | ((bitv(w, i-1) | bitv(w, i-2)) & (bitv(w, i+1) | bitv(w, i+2)));
    return o;
  endfunction

  function automatic word_t ref_maj(word_t w);  // R5
    word_t o;
    logic a, b, c;
    for (int i = 0; i < TW; i++) begin
      a = bitv(w, i-1); b = w[i]; c = bitv(w, i+1);
      o[i] = (a & b) | (a & c) | (b & c);
    end
    return o;
  endfunction

  function automatic int ones(word_t w);
    int n = 0;
    for (int i = 0; i < TW; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic bit is_clean(word_t w);
    int n = ones(w);
    for (int i = 0; i < TW; i++) if (w[i] != (i < n)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic word_t therm_of(int k);
    word_t w = '0;
    for (int i = 0; i < TW; i++) w[i] = (i < k);
    return w;
  endfunction

  function automatic word_t rnd_word();
    word_t w;
    int k, pos;
    if ($urandom_range(0, 7) == 0) begin
      for (int i = 0; i < TW; i++) w[i] = $urandom_range(0, 1) == 1;
      return w;
    end
    k = $urandom_range(0, TW);
    w = therm_of(k);
    for (int f = $urandom_range(0, 3); f > 0; f--) begin
      pos = k + $urandom_range(0, 6) - 3;
      if (pos < 0) pos = 0;
      if (pos > TW - 1) pos = TW - 1;
      w[pos] = ~w[pos];
    end
    return w;
  endfunction

  function automatic int lat(int m);
    case (m)
      1: return 3;
      3: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic push(word_t w);
    word_t c, c1;
    int b;
    string tag;
    case (bmode)
      0: begin c = ref_one(w); tag = "R2"; end
      1: begin c = ref_two(w); tag = "R4"; end
      2: begin c = ref_maj(w); tag = "R5"; end
      default: begin
        c1 = ref_one(w);
        c  = (c1 & h1) | (c1 & h2) | (h1 & h2);
        h2 = h1; h1 = c1;
        tag = "R6";
      end
    endcase
    if (is_clean(w) && bmode != 3) tag = {tag, "/R3"};
    b = ones(c);                                   // R1
    if (bgray) begin
      b = b ^ (b >> 1);                            // R7
      tag = {tag, "/R7"};
    end
    exp_code[tail] = b;
    exp_bub[tail]  = !is_clean(w);
    exp_due[tail]  = cyc + 1 + lat(bmode);
    exp_tag[tail]  = tag;
    tail++;
  endtask

  task automatic send(word_t w);
    @(negedge clk);
    therm_i = w; valid_i = 1'b1;
    push(w);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); valid_i = 1'b0; end
  endtask

  task automatic send_rand(int n);
    for (int j = 0; j < n; j++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      send(rnd_word());
    end
  endtask

  // R10: mismatching mode drops samples and silences output for 5 cycles
  task automatic set_mode(int m);
    idle(7);
    @(negedge clk);
    mode_i = 2'(m); valid_i = 1'b1; therm_i = rnd_word();
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      therm_i = rnd_word(); valid_i = 1'b1;
      check(valid_o == 1'b0, "R10 valid during change", int'(valid_o), 0);
    end
    bmode = m; h1 = '0; h2 = '0;
  endtask

  task automatic set_fmt(bit g);
    idle(7);
    gray_i = g; bgray = g;
  endtask

  // ---------------- output monitor (R8, R9) ----------------
  always @(negedge clk) begin
    if (mon_on) begin
      if (valid_o) begin
        if (head == tail) begin
          check(1'b0, "R9 unexpected valid", 1, 0);
        end else if (exp_due[head] != cyc) begin
          check(1'b0, "R9 arrival cycle", cyc, exp_due[head]);
          head++;
        end else begin
          check(int'(code_o) == exp_code[head], exp_tag[head], int'(code_o), exp_code[head]);
          check(bubble_o == exp_bub[head], "R8 bubble flag", int'(bubble_o), int'(exp_bub[head]));
          head++;
        end
      end else begin
        if (head != tail && exp_due[head] < cyc) begin
          check(1'b0, "R9 missing result", cyc, exp_due[head]);
          head++;
        end
        if (bubble_o) check(1'b0, "R8 flag without valid", 1, 0);
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(valid_o == 1'b0, "R11 valid after reset", int'(valid_o), 0);
    check(code_o == '0, "R11 code after reset", int'(code_o), 0);
    check(bubble_o == 1'b0, "R11 bubble after reset", int'(bubble_o), 0);
    mon_on = 1'b1;

    // mode 0 active from reset (R11), directed corners R1 R2 R3
    send('0);
    send('1);
    send(word_t'(5));            // 1-0-1 repaired to 3
    send(word_t'(6));            // missing bit 0, virtual one below fills it
    send(word_t'(1) << (TW-1));  // lone top bit, not repaired
    send(therm_of(20));
    idle(3);
    // R9: code holds between results
    check(int'(code_o) == 20, "R9 code holds", int'(code_o), 20);
    send_rand(200);

    // R7 Gray, monotone ramp plus random
    set_fmt(1'b1);
    for (int k = 0; k <= TW; k++) send(therm_of(k));
    send_rand(100);
    set_fmt(1'b0);

    // R4 double gap
    set_mode(1);
    send(word_t'(9));            // 1-0-0-1 filled to 4
    send(word_t'(9) << 10 | therm_of(10));
    send_rand(200);

    // R5 majority
    set_mode(2);
    send(word_t'(1) << 40);      // isolated one removed
    send(word_t'(2));            // bit 0 kept by virtual one
    send_rand(200);

    // R6 temporal filter, history starts at zero
    set_mode(3);
    send(therm_of(30));
    send(therm_of(30));
    send(therm_of(30));
    send(therm_of(5));           // transient, outvoted
    send_rand(200);

    // back to single-gap mode, Gray on
    set_mode(0);
    set_fmt(1'b1);
    send_rand(100);

    idle(10);
    check(head == tail, "R9 all results delivered", tail - head, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule